// File: doc/BRIEF.md
# GPIB Source Handshake Engine

This block is the talker side of the three-wire byte handshake on an 8-bit parallel instrument bus. A local producer offers one byte at a time together with an end-of-message flag. The engine copies the byte into a holding register and places it on the data lines. After a fixed settling time, and once the acceptors stop signalling "not ready for data", it asserts "data valid". It then waits for the acceptors to release "no data accepted". When they do, it withdraws the byte and gives the producer a one-cycle consumed pulse.

An enable input grants the engine the right to source, whether as active talker or as active controller. Dropping the enable aborts any transfer at once and cancels the settling timer. The two acceptor status lines come from outside the clock domain, so they pass through a synchronizer before the sequencer uses them. All bus lines are handled in positive logic. Polarity conversion belongs to the pad ring.

Top module: `gpib_src_hs`

## Requirements
- R1: While reset is held and in the first cycle after its release, DAV, EOI and all data lines are low and the consumed pulse is low.
- R2: With the enable low, no byte-valid, NRFD or NDAC activity raises DAV, drives the data lines or produces a consumed pulse.
- R3: With the enable high and the engine waiting for a byte, a byte-valid seen at a clock edge places that byte and its EOI flag on the bus right after that edge. DAV stays low at that point.
- R4: When NRFD has been low long enough to be synchronized, DAV rises exactly SETTLE_CYC clock edges after the byte first appears on the bus.
- R5: While NRFD is high, DAV stays low however long the settling time has been exceeded. With the default two-stage synchronizer, DAV rises on the third clock edge after NRFD falls.
- R6: From the moment a byte is placed on the bus until it is withdrawn, the data lines and EOI do not change. Changes of byte-valid, the offered byte or its flag during that time are ignored.
- R7: While DAV is high, NDAC falling makes the consumed pulse high for exactly one cycle after the second clock edge. DAV, EOI and the data lines all return to zero on the third edge.
- R8: After a consumed pulse, a byte already offered is taken on the second following edge and appears on the bus then, with no idle gap beyond that.
- R9: The enable falling in the settling or the transfer phase drops DAV, EOI and the data lines on the next edge with no consumed pulse. When the enable returns, the same offered byte is sent again with the full settling time.
- R10: Every DAV assertion carries the offered bytes and EOI flags in offer order, none lost and none extra.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| talk_en | input | 1 | Engine is permitted to source (talker or controller active) |
| byte_vld | input | 1 | Producer offers a byte |
| byte_dat | input | 8 | Offered byte |
| byte_eoi | input | 1 | Offered byte ends the message |
| byte_taken | output | 1 | One-cycle pulse: offered byte was accepted by the bus |
| bus_nrfd | input | 1 | Acceptors not ready for data (asynchronous) |
| bus_ndac | input | 1 | Acceptors have not accepted data (asynchronous) |
| bus_dav | output | 1 | Data valid |
| bus_data | output | 8 | Data lines |
| bus_eoi | output | 1 | End-or-identify line accompanying the byte |

## Verification
The hardest situation to reach from the ports is the enable dropping while DAV is already high and NDAC falls in the same moment. If that case were handled wrongly, the aborted byte would be counted as consumed and lost. The stimulus parks a transfer with NDAC held high, then lowers the enable and NDAC on the same cycle. It watches that no consumed pulse appears, and it expects the scoreboard to receive the same byte a second time after the enable returns. A similar abort in the settling phase checks that the timer restarts from the full count rather than resuming.

// File: rtl/gpib_src_pkg.sv
package gpib_src_pkg;

    // Width of the parallel data bus
    localparam int unsigned BUS_W = 8;

    // Source sequencer states
    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,   // not permitted to source
        SRC_GEN  = 2'd1,   // waiting for a byte from the producer
        SRC_DLY  = 2'd2,   // byte on bus, settling
        SRC_XFER = 2'd3    // DAV asserted, waiting for acceptance
    } src_state_e;

    // Byte captured for one transfer
    typedef struct packed {
        logic             eoi;
        logic [BUS_W-1:0] dat;
    } src_word_t;

    // True in the states where the captured byte is on the lines
    function automatic logic holds_bus(src_state_e s);
        return (s == SRC_DLY) || (s == SRC_XFER);
    endfunction

    // Counter width able to hold values 0..n-1
    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/gpib_src_sync.sv
module gpib_src_sync #(
    parameter int unsigned        WIDTH   = 2,
    parameter int unsigned        STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VAL}};
                else     stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VAL}};
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpib_src_timer.sv
module gpib_src_timer #(
    parameter int unsigned CYCLES = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    output logic done
);
    import gpib_src_pkg::*;

    localparam int unsigned CW   = cnt_width(CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= LOAD;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);

    // once expired, the timer stays expired until cancelled or restarted
    AST_TMR_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        done && !cancel && !start |=> done); // R4

    // a fresh start never reports expiry on the following cycle unless one cycle is configured
    AST_TMR_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
        start && !cancel && (CYCLES > 1) |=> !done); // R4

endmodule

// File: rtl/gpib_src_ctl.sv
module gpib_src_ctl
    import gpib_src_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             talk_en,
    input  logic             byte_vld,
    input  logic [BUS_W-1:0] byte_dat,
    input  logic             byte_eoi,
    input  logic             nrfd_s,
    input  logic             ndac_s,
    input  logic             tmr_done,
    output logic             tmr_start,
    output logic             byte_taken,
    output logic             bus_dav,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_eoi
);

    src_state_e state_q, state_d;
    src_word_t  hold_q;

    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        if (!talk_en) begin
            state_d = SRC_IDLE;
        end else begin
            unique case (state_q)
                SRC_IDLE: state_d = SRC_GEN;
                SRC_GEN: begin
                    if (byte_vld) begin
                        state_d   = SRC_DLY;
                        tmr_start = 1'b1;
                    end
                end
                SRC_DLY: begin
                    if (tmr_done && !nrfd_s) state_d = SRC_XFER;
                end
                SRC_XFER: begin
                    if (!ndac_s) state_d = SRC_GEN;
                end
                default: state_d = SRC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SRC_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (tmr_start) hold_q <= '{eoi: byte_eoi, dat: byte_dat};
        end
    end

    assign bus_dav    = (state_q == SRC_XFER);
    assign bus_data   = holds_bus(state_q) ? hold_q.dat : '0;
    assign bus_eoi    = holds_bus(state_q) ? hold_q.eoi : 1'b0;
    assign byte_taken = talk_en && (state_q == SRC_XFER) && !ndac_s;

    // data and EOI stay put for as long as DAV is high
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
        bus_dav && $past(bus_dav) |-> $stable(bus_data) && $stable(bus_eoi)); // R6

    // DAV rises only after the settling timer expired with NRFD low
    AST_DAV_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_dav) |-> $past(tmr_done) && !$past(nrfd_s)); // R4

    // consumed is a single-cycle pulse
    AST_TAKEN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        byte_taken |=> !byte_taken); // R7

    // losing the enable clears the bus on the next edge
    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !talk_en |=> !bus_dav && (bus_data == '0) && !bus_eoi); // R9

    // DAV never appears without a settling phase before it
    AST_DAV_FROM_DLY: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_dav) |-> $past(state_q == SRC_DLY)); // R4

endmodule

// File: rtl/gpib_src_hs.sv
module gpib_src_hs #(
    parameter int unsigned SETTLE_CYC  = 250,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       talk_en,
    input  logic       byte_vld,
    input  logic [7:0] byte_dat,
    input  logic       byte_eoi,
    output logic       byte_taken,
    input  logic       bus_nrfd,
    input  logic       bus_ndac,
    output logic       bus_dav,
    output logic [7:0] bus_data,
    output logic       bus_eoi
);
    import gpib_src_pkg::*;

    localparam int unsigned SYNC_W = 2;

    logic [SYNC_W-1:0] line_s;
    logic              nrfd_s, ndac_s;
    logic              tmr_start, tmr_done;

    gpib_src_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({SYNC_W{1'b1}})
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_nrfd, bus_ndac}),
        .q   (line_s)
    );

    assign nrfd_s = line_s[1];
    assign ndac_s = line_s[0];

    gpib_src_timer #(
        .CYCLES (SETTLE_CYC)
    ) i_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (tmr_start),
        .cancel (!talk_en),
        .done   (tmr_done)
    );

    gpib_src_ctl i_ctl (
        .clk        (clk),
        .rst        (rst),
        .talk_en    (talk_en),
        .byte_vld   (byte_vld),
        .byte_dat   (byte_dat),
        .byte_eoi   (byte_eoi),
        .nrfd_s     (nrfd_s),
        .ndac_s     (ndac_s),
        .tmr_done   (tmr_done),
        .tmr_start  (tmr_start),
        .byte_taken (byte_taken),
        .bus_dav    (bus_dav),
        .bus_data   (bus_data),
        .bus_eoi    (bus_eoi)
    );

endmodule

// File: tb/test_gpib_src_hs.sv
module test_gpib_src_hs;

    localparam int S = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       talk_en, byte_vld, byte_eoi;
    logic [7:0] byte_dat;
    logic       man_nrfd, man_ndac, auto_acc, acc_ndac;
    logic       byte_taken, bus_dav, bus_eoi;
    logic [7:0] bus_data;
    logic       bus_ndac;

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0] exp_q[$];
    logic prev_dav;

    always #4 clk = ~clk;

    assign bus_ndac = auto_acc ? acc_ndac : man_ndac;

    gpib_src_hs #(.SETTLE_CYC(S)) i_gpib_src_hs (
        .clk(clk), .rst(rst), .talk_en(talk_en), .byte_vld(byte_vld),
        .byte_dat(byte_dat), .byte_eoi(byte_eoi), .byte_taken(byte_taken),
        .bus_nrfd(man_nrfd), .bus_ndac(bus_ndac), .bus_dav(bus_dav),
        .bus_data(bus_data), .bus_eoi(bus_eoi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_exp(input logic [7:0] d, input logic e);
        exp_q.push_back({e, d});
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // wait at falling edges for the consumed pulse; returns cycles waited or -1
    task automatic wait_taken(output int waited);
        waited = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (byte_taken) begin
                waited = i;
                break;
            end
        end
    endtask

    // acceptor model: releases NDAC while it sees DAV
    always @(negedge clk) acc_ndac = rst ? 1'b1 : !bus_dav;

    // scoreboard monitor: each DAV rise must carry the next expected byte
    always @(negedge clk) begin
        logic [8:0] x;
        if (rst) begin
            prev_dav = 1'b0;
        end else begin
            if (bus_dav && !prev_dav) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected DAV", {bus_eoi, bus_data}, 0);
                end else begin
                    x = exp_q.pop_front();
                    chk({bus_eoi, bus_data} == x, "R10 scoreboard byte", {bus_eoi, bus_data}, x);
                end
            end
            prev_dav = bus_dav;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        int viol;
        int w;
        logic [7:0] seq [4];
        seq[0] = 8'h11; seq[1] = 8'h22; seq[2] = 8'h33; seq[3] = 8'h44;

        rst = 1'b1; talk_en = 1'b0; byte_vld = 1'b0; byte_dat = 8'h00; byte_eoi = 1'b0;
        man_nrfd = 1'b0; man_ndac = 1'b1; auto_acc = 1'b0;
        repeat (4) @(negedge clk);
        chk(!bus_dav && bus_data == 0 && !bus_eoi && !byte_taken, "R1 during reset",
            {bus_dav, bus_eoi, bus_data}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_dav && bus_data == 0 && !bus_eoi && !byte_taken, "R1 after reset",
            {byte_taken, bus_dav, bus_eoi, bus_data}, 0);

        // R2: disabled engine ignores everything
        byte_vld = 1'b1; byte_dat = 8'h5A; man_ndac = 1'b0;
        viol = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_dav || bus_data != 0 || bus_eoi || byte_taken) viol++;
        end
        chk(viol == 0, "R2 disabled quiet", viol, 0);
        byte_vld = 1'b0; man_ndac = 1'b1;
        repeat (3) @(negedge clk);

        // R3 / R4 / R6
        talk_en = 1'b1;
        repeat (4) @(negedge clk);
        push_exp(8'hA5, 1'b1);
        byte_vld = 1'b1; byte_dat = 8'hA5; byte_eoi = 1'b1;
        @(negedge clk);
        chk(bus_data == 8'hA5 && bus_eoi, "R3 byte on bus", {bus_eoi, bus_data}, 9'h1A5);
        chk(!bus_dav, "R3 DAV low at first", bus_dav, 0);
        byte_vld = 1'b0; byte_dat = 8'h00; byte_eoi = 1'b0;
        viol = 0;
        for (int i = 2; i <= S; i++) begin
            @(negedge clk);
            if (bus_dav || bus_data != 8'hA5 || !bus_eoi) viol++;
        end
        chk(viol == 0, "R4 R6 settle phase", viol, 0);
        @(negedge clk);
        chk(bus_dav, "R4 DAV after settle", bus_dav, 1);
        chk(bus_data == 8'hA5 && bus_eoi, "R6 held byte ignores input", {bus_eoi, bus_data}, 9'h1A5);

        // R7: completion by NDAC
        viol = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!bus_dav || byte_taken) viol++;
        end
        chk(viol == 0, "R7 waits for NDAC", viol, 0);
        man_ndac = 1'b0;
        @(negedge clk);
        chk(bus_dav && !byte_taken, "R7 first edge", {bus_dav, byte_taken}, 2);
        @(negedge clk);
        chk(byte_taken && bus_dav, "R7 consumed pulse", {bus_dav, byte_taken}, 3);
        @(negedge clk);
        chk(!byte_taken && !bus_dav && bus_data == 0 && !bus_eoi, "R7 bus released",
            {byte_taken, bus_dav, bus_eoi, bus_data}, 0);
        man_ndac = 1'b1;
        repeat (3) @(negedge clk);

        // R5: NRFD holds the transfer back
        man_nrfd = 1'b1;
        push_exp(8'h3C, 1'b0);
        byte_vld = 1'b1; byte_dat = 8'h3C; byte_eoi = 1'b0;
        viol = 0;
        for (int i = 0; i < S + 6; i++) begin
            @(negedge clk);
            if (bus_dav) viol++;
        end
        chk(viol == 0, "R5 NRFD blocks DAV", viol, 0);
        man_nrfd = 1'b0;
        @(negedge clk);
        chk(!bus_dav, "R5 edge one", bus_dav, 0);
        @(negedge clk);
        chk(!bus_dav, "R5 edge two", bus_dav, 0);
        @(negedge clk);
        chk(bus_dav && bus_data == 8'h3C, "R5 DAV on third edge", {bus_dav, bus_data}, 9'h13C);
        man_ndac = 1'b0;
        wait_taken(w);
        byte_vld = 1'b0;
        chk(w >= 0, "R7 consumed after NRFD case", w, 1);
        man_ndac = 1'b1;
        repeat (3) @(negedge clk);

        // R8: back to back with the acceptor model
        auto_acc = 1'b1;
        for (int k = 0; k < 4; k++) push_exp(seq[k], k == 3);
        byte_vld = 1'b1; byte_dat = seq[0]; byte_eoi = 1'b0;
        for (int k = 0; k < 4; k++) begin
            wait_taken(w);
            chk(w >= 0, "R8 byte consumed", w, 1);
            if (k < 3) begin
                byte_dat = seq[k+1]; byte_eoi = (k + 1 == 3);
                @(negedge clk);
                chk(bus_data == 0 && !bus_dav, "R8 gap cycle", {bus_dav, bus_data}, 0);
                @(negedge clk);
                chk(bus_data == seq[k+1], "R8 next byte at once", bus_data, seq[k+1]);
            end else begin
                byte_vld = 1'b0;
            end
        end
        repeat (4) @(negedge clk);
        auto_acc = 1'b0; man_ndac = 1'b1;
        repeat (3) @(negedge clk);

        // R9: enable dropped during settling
        push_exp(8'hC3, 1'b1);
        byte_vld = 1'b1; byte_dat = 8'hC3; byte_eoi = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_data == 8'hC3 && !bus_dav, "R9 in settle", {bus_dav, bus_data}, 8'hC3);
        talk_en = 1'b0;
        @(negedge clk);
        chk(!bus_dav && bus_data == 0 && !bus_eoi, "R9 drop in settle", {bus_dav, bus_eoi, bus_data}, 0);
        talk_en = 1'b1;
        @(negedge clk);
        chk(bus_data == 0, "R9 restart idle step", bus_data, 0);
        @(negedge clk);
        chk(bus_data == 8'hC3, "R9 byte offered again", bus_data, 8'hC3);
        viol = 0;
        for (int i = 2; i <= S; i++) begin
            @(negedge clk);
            if (bus_dav) viol++;
        end
        chk(viol == 0, "R9 full settle restarted", viol, 0);
        @(negedge clk);
        chk(bus_dav, "R9 DAV after restarted settle", bus_dav, 1);

        // R9: enable dropped during transfer together with NDAC
        push_exp(8'hC3, 1'b1);
        talk_en = 1'b0; man_ndac = 1'b0;
        @(negedge clk);
        chk(!bus_dav && bus_data == 0 && !byte_taken, "R9 drop in transfer",
            {byte_taken, bus_dav, bus_data}, 0);
        viol = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (byte_taken || bus_dav) viol++;
        end
        chk(viol == 0, "R9 no consumed pulse", viol, 0);
        man_ndac = 1'b1;
        repeat (3) @(negedge clk);
        talk_en = 1'b1;
        repeat (S + 4) @(negedge clk);
        chk(bus_dav && bus_data == 8'hC3, "R9 resent byte", {bus_dav, bus_data}, 9'h1C3);
        man_ndac = 1'b0;
        wait_taken(w);
        byte_vld = 1'b0;
        chk(w >= 0, "R9 resent consumed", w, 1);
        man_ndac = 1'b1;
        repeat (5) @(negedge clk);

        chk(exp_q.size() == 0, "R10 all bytes delivered", exp_q.size(), 0);
        finish_run();
    end

endmodule